// File: doc/BRIEF.md
# Request-to-Response Window Checker

This block is a synthesizable run-time monitor for on-chip use. It watches a start signal and a response signal and flags any exchange where the response arrives outside a two-sided window. Each rising transition of the start signal opens a window. The response must then be seen no earlier than `MIN_CYC` clock edges and no later than `MAX_CYC` clock edges after the edge that opened it. A response that comes too early is an error, and so is one that never comes.

All inputs are sampled on the rising clock edge. A detected violation produces a one-clock error pulse. A sticky flag also holds the error until the next reset. A new start event while a window is still open throws the old window away and starts timing again from zero. A common setting is `MIN_CYC=1`, `MAX_CYC=5`, which fits a request that must be acknowledged within a few cycles. The parameters must satisfy 1 <= `MIN_CYC` <= `MAX_CYC`.

Top module: `resp_window_checker`

## Requirements
- R1: While `rst_n` is low, `err_pulse` and `err_sticky` are 0 and no window is open; start or response activity during reset produces no error after release.
- R2: A window opens only on a rising transition of `start_evt` (sampled 0 at one edge and 1 at the next); a level held high opens no further windows.
- R3: If the response is sampled high at edge k after the opening edge, with `MIN_CYC` <= k <= `MAX_CYC`, no error is raised and the window closes, so later responses raise nothing.
- R4: If the response is sampled high at edge k with 1 <= k < `MIN_CYC`, `err_pulse` is 1 in the cycle after that edge, and the window closes.
- R5: If the response is low at every edge from 1 up to and including edge `MAX_CYC`, `err_pulse` is 1 in the cycle after edge `MAX_CYC`, and the window closes.
- R6: A rising transition of `start_evt` while a window is open restarts the count, so later edges are numbered from the new opening edge.
- R7: `err_pulse` lasts exactly one clock per violation. `err_sticky` is set together with the first pulse and stays 1 until `rst_n` is low.
- R8: A response while no window is open has no effect on either output.
- R9: If a rising transition of `start_evt` and a high response are sampled at the same edge, the start event takes precedence. The response at that edge is not judged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | Start signal; its rising transition opens a window |
| resp | input | 1 | Response signal, judged while a window is open |
| err_pulse | output | 1 | One-clock pulse for each window violation |
| err_sticky | output | 1 | Set by the first violation, cleared only by reset |

## Verification
The window state in this block surfaces at the ports only through `err_pulse`. A stale or miscounted elapsed value shows up as a pulse one or more cycles away from the early boundary (`MIN_CYC`-1 versus `MIN_CYC`) or the late boundary (`MAX_CYC`). A window that fails to close shows up as a late pulse about `MAX_CYC` cycles after a good response. A window that fails to restart shows up as a pulse timed from the discarded event. Every stimulus pattern is therefore chosen so that the wrong count yields a different pulse pattern within at most `MAX_CYC`+1 cycles.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  // Outcome of evaluating one sampling edge against the open window
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,  // nothing decided at this edge
    VERD_OK    = 2'd1,  // response inside window
    VERD_EARLY = 2'd2,  // response before minimum delay
    VERD_LATE  = 2'd3   // maximum delay reached with no response
  } verdict_t;

  function automatic bit verdict_is_error(verdict_t v);
    return (v == VERD_EARLY) || (v == VERD_LATE);
  endfunction

endpackage

// File: rtl/rwc_rise_detect.sv
module rwc_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_out
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise_out = level_in && !level_q;

  // R2
  rise_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_out |=> !rise_out);

endmodule

// File: rtl/rwc_window_timer.sv
module rwc_window_timer
  import rwc_pkg::*;
#(
  parameter int MIN_CYC = 1,
  parameter int MAX_CYC = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     open_req,
  input  logic     resp,
  output verdict_t verdict
);

  localparam int CW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
  localparam logic [CW:0] MIN_V = (CW + 1)'(MIN_CYC);
  localparam logic [CW:0] MAX_V = (CW + 1)'(MAX_CYC);

  logic          win_open;
  logic [CW-1:0] elapsed_q;
  logic [CW:0]   edge_no;

  // number of this edge counted from the opening edge
  assign edge_no = {1'b0, elapsed_q} + (CW + 1)'(1);

  always_comb begin
    verdict = VERD_NONE;
    if (!open_req && win_open) begin
      if (resp)                 verdict = (edge_no < MIN_V) ? VERD_EARLY : VERD_OK;
      else if (edge_no == MAX_V) verdict = VERD_LATE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open  <= 1'b0;
      elapsed_q <= '0;
    end else if (open_req) begin
      win_open  <= 1'b1;
      elapsed_q <= '0;
    end else if (verdict != VERD_NONE) begin
      win_open  <= 1'b0;
      elapsed_q <= '0;
    end else if (win_open) begin
      elapsed_q <= edge_no[CW-1:0];
    end
  end

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |=> (win_open && elapsed_q == '0));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> ({1'b0, elapsed_q} < MAX_V));

endmodule

// File: rtl/rwc_error_report.sv
module rwc_error_report
  import rwc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_t verdict,
  output logic     err_pulse,
  output logic     err_sticky
);

  logic hit;
  assign hit = verdict_is_error(verdict);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse  <= hit;
      err_sticky <= err_sticky | hit;
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R7
  pulse_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

endmodule

// File: rtl/resp_window_checker.sv
module resp_window_checker
  import rwc_pkg::*;
#(
  parameter int MIN_CYC = 1,
  parameter int MAX_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic resp,
  output logic err_pulse,
  output logic err_sticky
);

  logic     start_rise;
  verdict_t verdict;

  rwc_rise_detect u_rise (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (start_evt),
    .rise_out (start_rise)
  );

  rwc_window_timer #(
    .MIN_CYC (MIN_CYC),
    .MAX_CYC (MAX_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_req (start_rise),
    .resp     (resp),
    .verdict  (verdict)
  );

  rwc_error_report u_report (
    .clk        (clk),
    .rst_n      (rst_n),
    .verdict    (verdict),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky)
  );

endmodule

// File: tb/test_resp_window_checker.sv
`timescale 1ns/1ps
module test_resp_window_checker;

  localparam int MIN_CYC = 3;
  localparam int MAX_CYC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_evt = 1'b0;
  logic resp = 1'b0;
  logic err_pulse, err_sticky;

  always #5 clk = ~clk;

  resp_window_checker #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) i_resp_window_checker (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .resp(resp),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  typedef struct {
    logic  err;
    logic  stk;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic stk_model = 1'b0;
  bit   done = 1'b0;

  // Driver: inputs take effect at the next rising edge; expected outputs
  // are those right after that edge.
  task automatic step(input logic r, input logic s, input logic a,
                      input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    rst_n = r; start_evt = s; resp = a;
    if (!r) stk_model = 1'b0;
    else    stk_model = stk_model | e;
    x.err = r ? e : 1'b0;
    x.stk = stk_model;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, tag);
  endtask

  // Monitor: compares outputs 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_cmp++;
      if (err_pulse !== x.err || err_sticky !== x.stk) begin
        n_bad++;
        $display("FAIL %s: err_pulse=%b err_sticky=%b expected %b %b at %0t",
                 x.tag, err_pulse, err_sticky, x.err, x.stk, $time);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: activity during reset is ignored
    step(0, 1, 1, 0, "R1");
    step(0, 0, 1, 0, "R1");
    step(0, 1, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    idle(2, "R1");

    // R3: response at edge MIN_CYC is good; later responses ignored
    step(1, 1, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    idle(6, "R3");

    // R8: response with no window open
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, "R8");
    idle(1, "R8");

    // R3: response exactly at edge MAX_CYC
    step(1, 1, 0, 0, "R3");
    for (int i = 1; i < MAX_CYC; i++) step(1, 0, 0, 0, "R3");
    step(1, 0, 1, 0, "R3");
    idle(3, "R3");

    // R4: response at edge 1 is early; window then closed
    step(1, 1, 0, 0, "R4");
    step(1, 0, 1, 1, "R4");
    idle(6, "R4");

    // R4: response at edge MIN_CYC-1 is early
    step(1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, "R4");
    step(1, 0, 1, 1, "R4");
    idle(6, "R4");

    // R5 / R2 / R7: start held high, no response -> one late pulse only
    step(1, 1, 0, 0, "R5");
    for (int i = 1; i < MAX_CYC; i++) step(1, 1, 0, 0, "R5");
    step(1, 1, 0, 1, "R5");
    step(1, 1, 0, 0, "R7");
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, "R2");
    idle(2, "R2");

    // R6: restart at edge 3; old deadline passes silently, new one fires
    step(1, 1, 0, 0, "R6");
    step(1, 0, 0, 0, "R6");
    step(1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, "R6");
    for (int i = 1; i < MAX_CYC; i++) step(1, 0, 0, 0, "R6");
    step(1, 0, 0, 1, "R6");
    idle(2, "R6");

    // R9: new event and response at the same edge; response not judged
    step(1, 1, 0, 0, "R9");
    step(1, 0, 0, 0, "R9");
    step(1, 1, 1, 0, "R9");
    step(1, 0, 0, 0, "R9");
    step(1, 0, 0, 0, "R9");
    step(1, 0, 1, 0, "R9");
    idle(3, "R9");

    // R7: sticky flag clears only through reset
    step(0, 0, 0, 0, "R7");
    idle(2, "R7");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule